// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router

This block is one switch of a two-dimensional mesh network-on-chip. It has five link pairs: four to the neighbouring switches (north, east, south, west) and one to the resource attached locally. Every link direction carries a 32-bit data word, two framing bits (packet begin and packet end) and a valid/acknowledge pair. Each input holds arriving flits in an eight-entry queue. The switch's own mesh coordinates come in on `my_x`/`my_y`.

The flit at the front of an input queue goes through three steps. It is first presented as a candidate, then routed, then arbitrated at an output. When the front flit starts a packet, its destination coordinates are compared with the switch's own coordinates, using X-first then Y dimension order, to choose one output. Each output has a small state machine with two states. In `ST_IDLE` the output looks for headers that want it and picks one by round-robin, starting from a rotating pointer. The *grant* transition moves it to `ST_BUSY`, where the chosen input stays locked to that output. Body flits then follow without being routed again. When the flit carrying the end bit is acknowledged, the *release* transition returns the output to `ST_IDLE`, and the pointer moves to the input just after the one that finished. The crossbar lets all five outputs forward flits from different inputs in the same cycle.

Top module: `mesh_router`

## Requirements
- R1: After reset every `out_valid` bit is 0 and every `in_ack` bit is 1.
- R2: Each input queue holds exactly 8 flits. With its output blocked, an input accepts 8 flits, then holds `in_ack` low until space frees. No accepted flit is lost or reordered.
- R3: A flit with its begin bit set is a header. Its destination X is data bits [3:0] and its destination Y is data bits [7:4]. Coordinate bits in body flits are never used for routing.
- R4: A header goes east (port 2) if dest X > own X, west (port 4) if dest X < own X. Otherwise it goes north (port 1) if dest Y > own Y, south (port 3) if dest Y < own Y, else local (port 0).
- R5: Once an output grants a header, every flit of that packet up to and including the end-bit flit leaves on that output with no flit of another packet in between. A flit appears only on the output its packet was routed to.
- R6: Each output picks among waiting headers by searching from its pointer upward, wrapping after port 4. The pointer starts at 0 and changes only when an end-bit flit is acknowledged, becoming the finishing input's index plus one (mod 5).
- R7: Five packets from five different inputs to five different outputs are all forwarded in the same cycles.
- R8: A flit moves on a link only at a clock edge where valid and acknowledge are both 1. While `out_valid` is 1 and `out_ack` is 0, the output keeps the same flit and keeps valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_x | input | COORD_W | Own X coordinate |
| my_y | input | COORD_W | Own Y coordinate |
| in_valid | input | 5 | Per-input flit valid from the upstream sender |
| in_ack | output | 5 | Per-input acknowledge (queue has space) |
| in_bop | input | 5 | Per-input begin-of-packet bit |
| in_eop | input | 5 | Per-input end-of-packet bit |
| in_data | input | 5*DATA_W | Per-input flit data, port p at bits [p*DATA_W +: DATA_W] |
| out_valid | output | 5 | Per-output flit valid |
| out_ack | input | 5 | Per-output acknowledge from downstream |
| out_bop | output | 5 | Per-output begin-of-packet bit |
| out_eop | output | 5 | Per-output end-of-packet bit |
| out_data | output | 5*DATA_W | Per-output flit data, port p at bits [p*DATA_W +: DATA_W] |

## Verification
The bench sweeps every destination in a 4x4 coordinate range from every input, at two different own positions. Body flits carry deliberately wrong coordinates, so a switch that re-routes body flits, or that swaps the east/west or north/south comparisons, delivers flits to the wrong output, and the per-output scoreboard reports them. Three inputs contend for one output after a single earlier packet has moved the pointer. The bench expects the order 4, 1, 2; a fixed-priority or reset-pointer arbiter gives 1, 2, 4 instead. Another phase blocks an output to show that the queue takes exactly eight flits and then holds the last flit stable. A random-acknowledge phase shows that no flit is dropped or interleaved, and a five-way parallel burst exposes a crossbar that serializes disjoint transfers.

// File: rtl/router_pkg.sv
`timescale 1ns/1ps
package router_pkg;
    localparam int NPORTS = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/flit_fifo.sv
`timescale 1ns/1ps
module flit_fifo #(
    parameter int WIDTH = 34,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the queue never holds more than DEPTH entries
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R2: upstream gating never writes into a full queue
    a_r2_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
    // R8: nothing is read from an empty queue
    a_r8_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en);
endmodule

// File: rtl/xy_route.sv
`timescale 1ns/1ps
module xy_route import router_pkg::*; #(
    parameter int COORD_W = 4
) (
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic [COORD_W-1:0] my_x,
    input  logic [COORD_W-1:0] my_y,
    output port_e              dir
);
    always_comb begin
        if (dest_x > my_x)      dir = P_EAST;
        else if (dest_x < my_x) dir = P_WEST;
        else if (dest_y > my_y) dir = P_NORTH;
        else if (dest_y < my_y) dir = P_SOUTH;
        else                    dir = P_LOCAL;
    end
endmodule

// File: rtl/out_arbiter.sv
`timescale 1ns/1ps
module out_arbiter import router_pkg::*; #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] src_valid,
    input  logic [N-1:0] src_eop,
    input  logic         out_ack,
    output logic [N-1:0] gnt,
    output logic         out_valid,
    output logic         fire
);
    localparam int IW = $clog2(N);

    arb_state_e    state, state_nxt;
    logic [IW-1:0] owner, ptr, pick_idx;
    logic          pick_any, release_now;

    // Round-robin search starting at ptr; the smallest offset wins.
    always_comb begin
        int tmp;
        pick_any = 1'b0;
        pick_idx = ptr;
        for (int k = N - 1; k >= 0; k--) begin
            tmp = int'(ptr) + k;
            if (tmp >= N) tmp = tmp - N;
            if (req[tmp]) begin
                pick_any = 1'b1;
                pick_idx = IW'(tmp);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (pick_any)    state_nxt = ST_BUSY;
            ST_BUSY: if (release_now) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register, owner and pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
            ptr   <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && pick_any) owner <= pick_idx;
            if (release_now)
                ptr <= (owner == IW'(N - 1)) ? '0 : owner + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        gnt       = '0;
        out_valid = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_BUSY: begin
                gnt[owner] = 1'b1;
                out_valid  = src_valid[owner];
            end
            default: ;
        endcase
        fire        = out_valid && out_ack;
        release_now = fire && src_eop[owner];
    end

    // R5: a locked output keeps its owner until the end flit passes
    a_r5_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !(fire && src_eop[owner]))
        |=> (state == ST_BUSY && $stable(owner)));
    // R6: after a release the pointer sits one past the finished input
    a_r6_ptr_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && fire && src_eop[owner])
        |=> (int'(ptr) == (int'($past(owner)) + 1) % N));
    // R6: the pointer never moves without a release
    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == ST_BUSY && fire && src_eop[owner]) |=> $stable(ptr));
    // R8: a flit that was not acknowledged is still offered next cycle
    a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ack) |=> (out_valid && $stable(owner)));
    // R5: at most one input granted per output
    a_r5_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
endmodule

// File: rtl/mesh_router.sv
`timescale 1ns/1ps
module mesh_router import router_pkg::*; #(
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 8,
    parameter int COORD_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [COORD_W-1:0]       my_x,
    input  logic [COORD_W-1:0]       my_y,
    input  logic [NPORTS-1:0]        in_valid,
    output logic [NPORTS-1:0]        in_ack,
    input  logic [NPORTS-1:0]        in_bop,
    input  logic [NPORTS-1:0]        in_eop,
    input  logic [NPORTS*DATA_W-1:0] in_data,
    output logic [NPORTS-1:0]        out_valid,
    input  logic [NPORTS-1:0]        out_ack,
    output logic [NPORTS-1:0]        out_bop,
    output logic [NPORTS-1:0]        out_eop,
    output logic [NPORTS*DATA_W-1:0] out_data
);
    localparam int FW    = DATA_W + 2;
    localparam int BOP_B = FW - 1;
    localparam int EOP_B = FW - 2;

    logic [FW-1:0]     head  [NPORTS];
    logic [FW-1:0]     oword [NPORTS];
    port_e             dir   [NPORTS];
    logic [NPORTS-1:0] req   [NPORTS];
    logic [NPORTS-1:0] gnt   [NPORTS];
    logic [NPORTS-1:0] fifo_full, fifo_empty, hd_valid, hd_bop, hd_eop;
    logic [NPORTS-1:0] pop, fire;

    // Input side: queue plus route computation on the front flit
    for (genvar i = 0; i < NPORTS; i++) begin : g_in
        flit_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (in_valid[i] & ~fifo_full[i]),
            .wr_data ({in_bop[i], in_eop[i], in_data[i*DATA_W +: DATA_W]}),
            .full    (fifo_full[i]),
            .rd_en   (pop[i]),
            .rd_data (head[i]),
            .empty   (fifo_empty[i])
        );
        assign in_ack[i]   = ~fifo_full[i];
        assign hd_valid[i] = ~fifo_empty[i];
        assign hd_bop[i]   = head[i][BOP_B];
        assign hd_eop[i]   = head[i][EOP_B];

        xy_route #(.COORD_W(COORD_W)) u_route (
            .dest_x (head[i][COORD_W-1:0]),
            .dest_y (head[i][2*COORD_W-1:COORD_W]),
            .my_x   (my_x),
            .my_y   (my_y),
            .dir    (dir[i])
        );
    end

    // Only a waiting header requests its routed output
    always_comb begin
        for (int o = 0; o < NPORTS; o++)
            for (int i = 0; i < NPORTS; i++)
                req[o][i] = hd_valid[i] && hd_bop[i] && (dir[i] == port_e'(o));
    end

    // Output side: one arbiter per output
    for (genvar o = 0; o < NPORTS; o++) begin : g_out
        out_arbiter #(.N(NPORTS)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req[o]),
            .src_valid (hd_valid),
            .src_eop   (hd_eop),
            .out_ack   (out_ack[o]),
            .gnt       (gnt[o]),
            .out_valid (out_valid[o]),
            .fire      (fire[o])
        );
        assign out_bop[o]                      = oword[o][BOP_B];
        assign out_eop[o]                      = oword[o][EOP_B];
        assign out_data[o*DATA_W +: DATA_W]    = oword[o][DATA_W-1:0];

        // R8: an unacknowledged flit stays unchanged on the output
        a_r8_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[o] && !out_ack[o]) |=> $stable(oword[o]));
    end

    // Crossbar and queue pops
    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORTS; o++) begin
            oword[o] = '0;
            for (int i = 0; i < NPORTS; i++) begin
                if (gnt[o][i]) oword[o] = oword[o] | head[i];
                pop[i] = pop[i] | (fire[o] & gnt[o][i]);
            end
        end
    end

    // R5: an input is owned by at most one output at a time
    for (genvar i = 0; i < NPORTS; i++) begin : g_chk
        logic [NPORTS-1:0] owners;
        always_comb
            for (int o = 0; o < NPORTS; o++) owners[o] = gnt[o][i];
        a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owners));
        // R4: a header addressed to this switch requests only the local output
        a_r4_local_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            (hd_valid[i] && hd_bop[i] && head[i][COORD_W-1:0] == my_x &&
             head[i][2*COORD_W-1:COORD_W] == my_y) |-> (dir[i] == P_LOCAL));
    end
endmodule

// File: tb/sim_mesh_router.sv
`timescale 1ns/1ps
module sim_mesh_router;
    localparam int NP = 5;
    localparam int DW = 32;
    localparam int QD = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    my_x = 4'd1, my_y = 4'd2;
    logic [NP-1:0] in_valid = '0, in_bop = '0, in_eop = '0;
    logic [DW-1:0] din [NP];
    logic [NP*DW-1:0] in_data;
    logic [NP-1:0] in_ack, out_valid, out_bop, out_eop, out_ack;
    logic [NP*DW-1:0] out_data;
    logic [NP-1:0] ack_hold = 5'h1f;
    logic          ack_rand_en = 1'b0;
    logic [15:0]   lfsr = 16'hACE1;

    int checks = 0, fails = 0;
    logic [33:0] exp_mem [NP][QD];
    int wr_i [NP], rd_i [NP], acc_cnt [NP];
    int par_max = 0;
    logic [NP-1:0] prev_stall = '0;
    logic [33:0]   prev_word [NP];
    bit done = 0;

    always #2 clk = ~clk;

    always_comb for (int p = 0; p < NP; p++) in_data[p*DW +: DW] = din[p];
    assign out_ack = ack_rand_en ? lfsr[4:0] : ack_hold;
    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    mesh_router u0 (
        .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
        .in_valid(in_valid), .in_ack(in_ack), .in_bop(in_bop), .in_eop(in_eop),
        .in_data(in_data), .out_valid(out_valid), .out_ack(out_ack),
        .out_bop(out_bop), .out_eop(out_eop), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int route_of(int dx, int dy, int mx, int my);
        if (dx > mx) return 2;
        if (dx < mx) return 4;
        if (dy > my) return 1;
        if (dy < my) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] fword(int dx, int dy, int tag, int k);
        logic [7:0] c = {dy[3:0], dx[3:0]};
        return {tag[15:0], k[7:0], (k == 0) ? c : ~c};
    endfunction

    task automatic push_pkt(int o, int dx, int dy, int len, int tag);
        for (int k = 0; k < len; k++) begin
            exp_mem[o][wr_i[o] % QD] = {k == 0, k == len - 1, fword(dx, dy, tag, k)};
            wr_i[o]++;
        end
    endtask

    task automatic send_pkt(int p, int dx, int dy, int len, int tag);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid[p] = 1'b1;
            in_bop[p]   = (k == 0);
            in_eop[p]   = (k == len - 1);
            din[p]      = fword(dx, dy, tag, k);
            while (!in_ack[p]) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        bit busy = 1;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
            busy = |out_valid;
            for (int o = 0; o < NP; o++) if (rd_i[o] != wr_i[o]) busy = 1;
        end
        check(t < 3000, "R5 drain", 64'(t), 64'(3000));
    endtask

    // Output monitor and scoreboard
    always @(negedge clk) begin
        int par;
        logic [33:0] w;
        par = 0;
        if (rst_n) begin
            for (int p = 0; p < NP; p++) if (in_valid[p] && in_ack[p]) acc_cnt[p]++;
            for (int o = 0; o < NP; o++) begin
                w = {out_bop[o], out_eop[o], out_data[o*DW +: DW]};
                if (prev_stall[o])
                    check(out_valid[o] && w == prev_word[o], "R8 hold while stalled", 64'(w), 64'(prev_word[o]));
                prev_stall[o] = out_valid[o] && !out_ack[o];
                prev_word[o]  = w;
                if (out_valid[o] && out_ack[o]) begin
                    par++;
                    if (rd_i[o] == wr_i[o]) begin
                        check(0, "R4 unexpected flit on output", 64'(o), 64'(w));
                    end else begin
                        check(w == exp_mem[o][rd_i[o] % QD], "R5 flit order/content",
                              64'(w), 64'(exp_mem[o][rd_i[o] % QD]));
                        rd_i[o]++;
                    end
                end
            end
            if (par > par_max) par_max = par;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            din[p] = '0; wr_i[p] = 0; rd_i[p] = 0; acc_cnt[p] = 0; prev_word[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 5'h0, "R1 out_valid after reset", 64'(out_valid), 64'h0);
        check(in_ack == 5'h1f, "R1 in_ack after reset", 64'(in_ack), 64'h1f);

        // R6: contention on the local output, pointer moved by a first packet
        push_pkt(0, 1, 2, 4, 16'h100);
        send_pkt(2, 1, 2, 4, 16'h100);
        drain();
        push_pkt(0, 1, 2, 4, 16'h404);
        push_pkt(0, 1, 2, 4, 16'h401);
        push_pkt(0, 1, 2, 4, 16'h402);
        fork
            send_pkt(1, 1, 2, 4, 16'h401);
            send_pkt(2, 1, 2, 4, 16'h402);
            send_pkt(4, 1, 2, 4, 16'h404);
        join
        drain();
        check(rd_i[0] == 16, "R6 round-robin order served", 64'(rd_i[0]), 64'd16);

        // R2: fill an input queue with its output blocked
        @(negedge clk) ack_hold = 5'h00;
        acc_cnt[1] = 0;
        push_pkt(0, 1, 2, 10, 16'h222);
        fork
            send_pkt(1, 1, 2, 10, 16'h222);
            begin
                repeat (20) @(negedge clk);
                check(acc_cnt[1] == 8, "R2 flits accepted while blocked", 64'(acc_cnt[1]), 64'd8);
                check(in_ack[1] == 1'b0, "R2 in_ack low when full", 64'(in_ack[1]), 64'd0);
                check(in_ack[0] == 1'b1, "R2 other input unaffected", 64'(in_ack[0]), 64'd1);
                check(out_valid[0] && out_bop[0], "R8 header offered while stalled",
                      64'({out_valid[0], out_bop[0]}), 64'h3);
                ack_hold = 5'h1f;
            end
        join
        drain();

        // R7: five disjoint transfers at once
        par_max = 0;
        push_pkt(2, 2, 2, 6, 16'h500);
        push_pkt(4, 0, 2, 6, 16'h502);
        push_pkt(3, 1, 0, 6, 16'h501);
        push_pkt(1, 1, 3, 6, 16'h503);
        push_pkt(0, 1, 2, 6, 16'h504);
        fork
            send_pkt(0, 2, 2, 6, 16'h500);
            send_pkt(2, 0, 2, 6, 16'h502);
            send_pkt(1, 1, 0, 6, 16'h501);
            send_pkt(3, 1, 3, 6, 16'h503);
            send_pkt(4, 1, 2, 6, 16'h504);
        join
        drain();
        check(par_max == 5, "R7 parallel transfers", 64'(par_max), 64'd5);

        // R8/R5: random backpressure, several packets per input to distinct outputs
        @(negedge clk) ack_rand_en = 1'b1;
        for (int r = 0; r < 3; r++) begin
            push_pkt(2, 3, 2, 5, 16'h600 + r);
            push_pkt(4, 0, 1, 5, 16'h610 + r);
            push_pkt(3, 1, 0, 5, 16'h620 + r);
            push_pkt(1, 1, 3, 5, 16'h630 + r);
            push_pkt(0, 1, 2, 5, 16'h640 + r);
        end
        fork
            for (int r = 0; r < 3; r++) send_pkt(0, 3, 2, 5, 16'h600 + r);
            for (int r = 0; r < 3; r++) send_pkt(1, 0, 1, 5, 16'h610 + r);
            for (int r = 0; r < 3; r++) send_pkt(2, 1, 0, 5, 16'h620 + r);
            for (int r = 0; r < 3; r++) send_pkt(3, 1, 3, 5, 16'h630 + r);
            for (int r = 0; r < 3; r++) send_pkt(4, 1, 2, 5, 16'h640 + r);
        join
        drain();
        @(negedge clk) ack_rand_en = 1'b0;

        // R3/R4: routing sweep from every input, two own positions
        for (int m = 0; m < 2; m++) begin
            @(negedge clk);
            my_x = (m == 0) ? 4'd1 : 4'd2;
            my_y = (m == 0) ? 4'd2 : 4'd0;
            for (int p = 0; p < NP; p++)
                for (int dx = 0; dx < 4; dx++)
                    for (int dy = 0; dy < 4; dy++) begin
                        push_pkt(route_of(dx, dy, int'(my_x), int'(my_y)), dx, dy, 2,
                                 (m << 12) | (p << 8) | (dx << 4) | dy);
                        send_pkt(p, dx, dy, 2, (m << 12) | (p << 8) | (dx << 4) | dy);
                    end
            drain();
        end

        // R5: every expected flit delivered on its own output
        for (int o = 0; o < NP; o++)
            check(rd_i[o] == wr_i[o], "R5 all flits delivered", 64'(rd_i[o]), 64'(wr_i[o]));

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule